// File: doc/BRIEF.md
# I2C EEPROM Target Storage Core

This block is the storage half of a serial EEPROM that answers on an I2C bus. A bit-level front end, outside this block, turns bus traffic into byte-level operations: open a transfer to a 7-bit device address, hand over a written byte and take back an acknowledge, fetch a byte to send, and close the transfer. The core holds a byte array whose size is a power-of-two parameter, together with an internal byte pointer that the host sets through leading word-address bytes and that then steps through data bytes in both directions.

The array size fixes the word-address width. Arrays of 4096 bytes or more take two address bytes, sent most significant first. Smaller arrays take one. When the array is larger than the word address can reach, the core claims a block of consecutive device addresses, and the low bits of the chosen device address supply the upper memory-address bits. A build parameter can make the array read-only: data bytes are then still acknowledged and still move the pointer, but they are not stored. One operation is presented per cycle. Writes and reads act at the clock edge, while `rd_data`, `wr_ack` and `begin_hit` are combinational views of the present cycle.

Top module: `eep_target_core`

## Requirements
- R1: The word address is 16 bits (two address bytes) when MEM_BYTES is at least 4096, and 8 bits (one address byte) otherwise.
- R2: `begin_hit` is high exactly when `begin_addr` matches DEV_BASE in every bit except the low DEV_BITS bits, where DEV_BITS = max(0, log2(MEM_BYTES) − word-address bits). A 1024-byte array at base 0x50 claims 0x50 to 0x53, and a 4096-byte array at 0x57 claims only 0x57.
- R3: A begin to a claimed address places the low DEV_BITS bits of that address in pointer bits above the word address, clears every word-address bit, and restarts the address-byte count. A read with no address bytes therefore returns the byte at (dev_low << word bits).
- R4: Each written byte that arrives while the address-byte count is below the word-address byte count is shifted into the bottom of the word address, with earlier address bytes moving up. The device bits stay above it, and the result is masked to MEM_BYTES − 1.
- R5: With WRITABLE = 1, each written byte after the address bytes is stored at the pointer, and the pointer then steps by one.
- R6: On a read strobe `rd_data` shows the byte at the pointer, and the pointer steps by one at that edge.
- R7: A pointer step from MEM_BYTES − 1 goes to 0, for both reads and writes, across device-address blocks.
- R8: With WRITABLE = 0, data bytes are acknowledged and step the pointer, but the array keeps its contents.
- R9: `wr_ack` is high for every written byte while a transfer to a claimed address is open. After an end, or after a begin to an unclaimed address, writes get `wr_ack` low and change nothing.
- R10: After reset every byte reads 0xFF. A preload strobe (`pre_we`) writes `pre_data` at `pre_addr` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| begin_vld | input | 1 | Open a transfer to `begin_addr` |
| begin_addr | input | 7 | 7-bit device address of the transfer |
| begin_hit | output | 1 | `begin_addr` lies in the claimed block |
| end_vld | input | 1 | Close the current transfer |
| wr_vld | input | 1 | Written byte strobe |
| wr_data | input | 8 | Written byte |
| wr_ack | output | 1 | Acknowledge for the written byte |
| rd_vld | input | 1 | Read strobe, steps the pointer |
| rd_data | output | 8 | Byte at the pointer |
| pre_we | input | 1 | Direct preload strobe |
| pre_addr | input | log2(MEM_BYTES) | Preload byte address |
| pre_data | input | 8 | Preload byte |

## Verification
The bench drives three instances from one shared operation bus. The first is 1024 bytes at base 0x50 and writable: one address byte, with four claimed device addresses feeding two upper pointer bits. The second is 4096 bytes at 0x57: two address bytes, with a single claimed address whose high address bits must be masked away. The third is 256 bytes at 0x20 and read-only. Because the instances share one bus, every begin to one of them is an unclaimed begin for the other two. This checks deselection and silent acknowledge. Wraparound is checked through the last byte of the small and the wide arrays, and the dropped-write path is checked against bytes preloaded through the preload port.

// File: rtl/eep_pkg.sv
package eep_pkg;

    // Word-address width chosen from the array size.
    function automatic int word_addr_bits(input int mem_bytes);
        return (mem_bytes >= 4096) ? 16 : 8;
    endfunction

    // Device-address bits that extend the word address.
    function automatic int dev_sel_bits(input int aw, input int wlen);
        return (aw > wlen) ? (aw - wlen) : 0;
    endfunction

    // Decoded per-cycle actions of the byte interface.
    typedef struct packed {
        logic start;     // claimed begin
        logic addr_byte; // word-address byte
        logic data_byte; // data byte (stored or dropped)
        logic store;     // array write
        logic step;      // pointer advance
    } eep_op_t;

endpackage

// File: rtl/eep_claim.sv
module eep_claim #(
    parameter int DEV_BASE = 7'h50,
    parameter int DEV_BITS = 0
) (
    input  logic [6:0] dev_addr,
    output logic       hit
);
    localparam logic [6:0] SEL_MASK = 7'((1 << DEV_BITS) - 1);
    localparam logic [6:0] BASE     = 7'(DEV_BASE);

    always_comb hit = (((dev_addr ^ BASE) & ~SEL_MASK) == 7'd0);
endmodule

// File: rtl/eep_pointer.sv
module eep_pointer #(
    parameter int AW       = 10,
    parameter int WORD_LEN = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [6:0]    dev_addr,
    input  logic          addr_byte,
    input  logic          step,
    input  logic [7:0]    wr_data,
    output logic [AW-1:0] ptr,
    output logic          in_addr
);
    localparam int WIDE = WORD_LEN + 8;
    localparam int NB   = WORD_LEN / 8;

    logic [AW-1:0]       ptr_q;
    logic [1:0]          cnt_q;
    logic [6:0]          dev_q;
    logic [WORD_LEN-1:0] low_next;

    always_comb low_next = WORD_LEN'({ptr_q, wr_data});

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            cnt_q <= '0;
            dev_q <= '0;
        end else if (start) begin
            ptr_q <= AW'(WIDE'(dev_addr) << WORD_LEN);
            cnt_q <= '0;
            dev_q <= dev_addr;
        end else if (addr_byte) begin
            ptr_q <= AW'(WIDE'(low_next) | (WIDE'(dev_q) << WORD_LEN));
            cnt_q <= cnt_q + 2'd1;
        end else if (step) begin
            ptr_q <= ptr_q + AW'(1);
        end
    end

    assign ptr     = ptr_q;
    assign in_addr = (cnt_q < 2'(NB));

    // R3: a claimed begin clears the word address and the byte count
    a_r3_begin_origin: assert property (@(posedge clk) disable iff (rst)
        start |=> (ptr_q[7:0] == 8'd0) && (cnt_q == 2'd0));
    // R4: the address phase closes after the last address byte
    a_r4_addr_phase_ends: assert property (@(posedge clk) disable iff (rst)
        (addr_byte && !start && (cnt_q == 2'(NB - 1))) |=> !in_addr);
    // R6: plain step advances by one
    a_r6_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (step && !start && !addr_byte && (ptr_q != '1)) |=> ptr_q == $past(ptr_q) + AW'(1));
    // R7: step from the last byte wraps to zero
    a_r7_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (step && !start && !addr_byte && (ptr_q == '1)) |=> ptr_q == '0);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [7:0]    pre_data,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] valid;

    always_ff @(posedge clk) begin
        if (pre_we)  mem[pre_addr] <= pre_data;
        else if (we) mem[waddr]    <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)         valid <= '0;
        else if (pre_we) valid[pre_addr] <= 1'b1;
        else if (we)     valid[waddr]    <= 1'b1;
    end

    always_comb rdata = valid[raddr] ? mem[raddr] : 8'hFF;

    // R5: a port write lands at its address
    a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && !pre_we) |=> (mem[$past(waddr)] == $past(wdata)) && valid[$past(waddr)]);
    // R10: reset leaves every byte blank
    a_r10_blank_after_reset: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (valid == '0));
endmodule

// File: rtl/eep_target_core.sv
module eep_target_core #(
    parameter int MEM_BYTES = 1024,
    parameter int DEV_BASE  = 7'h50,
    parameter bit WRITABLE  = 1'b1,
    localparam int AW       = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          begin_vld,
    input  logic [6:0]    begin_addr,
    output logic          begin_hit,
    input  logic          end_vld,
    input  logic          wr_vld,
    input  logic [7:0]    wr_data,
    output logic          wr_ack,
    input  logic          rd_vld,
    output logic [7:0]    rd_data,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [7:0]    pre_data
);
    import eep_pkg::*;

    localparam int WORD_LEN = word_addr_bits(MEM_BYTES);
    localparam int DEV_BITS = dev_sel_bits(AW, WORD_LEN);

    logic          open_q;
    logic          hit;
    logic          in_addr;
    logic          wr_go;
    logic          rd_go;
    logic [AW-1:0] ptr;
    eep_op_t       op;

    eep_claim #(.DEV_BASE(DEV_BASE), .DEV_BITS(DEV_BITS)) u_claim (
        .dev_addr (begin_addr),
        .hit      (hit)
    );

    always_ff @(posedge clk) begin
        if (rst)            open_q <= 1'b0;
        else if (begin_vld) open_q <= hit;
        else if (end_vld)   open_q <= 1'b0;
    end

    always_comb begin
        wr_go        = wr_vld && open_q && !begin_vld && !end_vld;
        rd_go        = rd_vld && open_q && !begin_vld && !end_vld;
        op.start     = begin_vld && hit;
        op.addr_byte = wr_go && in_addr;
        op.data_byte = wr_go && !in_addr;
        op.store     = op.data_byte && WRITABLE;
        op.step      = op.data_byte || rd_go;
    end

    eep_pointer #(.AW(AW), .WORD_LEN(WORD_LEN)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .start     (op.start),
        .dev_addr  (begin_addr),
        .addr_byte (op.addr_byte),
        .step      (op.step),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .in_addr   (in_addr)
    );

    eep_store #(.AW(AW)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .we       (op.store),
        .waddr    (ptr),
        .wdata    (wr_data),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .raddr    (ptr),
        .rdata    (rd_data)
    );

    assign begin_hit = hit;
    assign wr_ack    = wr_go;

    // R9: a closed transfer acknowledges nothing in the next cycle
    a_r9_end_closes: assert property (@(posedge clk) disable iff (rst)
        (end_vld && !begin_vld) |=> !wr_ack);
    // R9: an unclaimed begin leaves the core deselected
    a_r9_foreign_begin: assert property (@(posedge clk) disable iff (rst)
        (begin_vld && !hit) |=> !wr_ack);
endmodule

// File: tb/eep_target_core_tb.sv
module eep_target_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        begin_vld = 1'b0;
    logic [6:0]  begin_addr = '0;
    logic        end_vld = 1'b0;
    logic        wr_vld = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_vld = 1'b0;
    logic [2:0]  pre_we = '0;
    logic [11:0] pre_addr = '0;
    logic [7:0]  pre_data = '0;

    logic [2:0]  hit_w, ack_w;
    logic [7:0]  rd0, rd1, rd2;
    logic [2:0]  hit_s, ack_s;
    logic [7:0]  rd_s [3];

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    eep_target_core #(.MEM_BYTES(1024), .DEV_BASE(7'h50), .WRITABLE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .begin_vld(begin_vld), .begin_addr(begin_addr),
        .begin_hit(hit_w[0]), .end_vld(end_vld), .wr_vld(wr_vld), .wr_data(wr_data),
        .wr_ack(ack_w[0]), .rd_vld(rd_vld), .rd_data(rd0), .pre_we(pre_we[0]),
        .pre_addr(pre_addr[9:0]), .pre_data(pre_data));

    eep_target_core #(.MEM_BYTES(4096), .DEV_BASE(7'h57), .WRITABLE(1'b1)) u_wide (
        .clk(clk), .rst(rst), .begin_vld(begin_vld), .begin_addr(begin_addr),
        .begin_hit(hit_w[1]), .end_vld(end_vld), .wr_vld(wr_vld), .wr_data(wr_data),
        .wr_ack(ack_w[1]), .rd_vld(rd_vld), .rd_data(rd1), .pre_we(pre_we[1]),
        .pre_addr(pre_addr), .pre_data(pre_data));

    eep_target_core #(.MEM_BYTES(256), .DEV_BASE(7'h20), .WRITABLE(1'b0)) u_ro (
        .clk(clk), .rst(rst), .begin_vld(begin_vld), .begin_addr(begin_addr),
        .begin_hit(hit_w[2]), .end_vld(end_vld), .wr_vld(wr_vld), .wr_data(wr_data),
        .wr_ack(ack_w[2]), .rd_vld(rd_vld), .rd_data(rd2), .pre_we(pre_we[2]),
        .pre_addr(pre_addr[7:0]), .pre_data(pre_data));

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic op_begin(input logic [6:0] a);
        @(negedge clk); begin_vld = 1'b1; begin_addr = a;
        #1 hit_s = hit_w;
        @(posedge clk); #1 begin_vld = 1'b0;
    endtask

    task automatic op_end();
        @(negedge clk); end_vld = 1'b1;
        @(posedge clk); #1 end_vld = 1'b0;
    endtask

    task automatic op_wr(input logic [7:0] d);
        @(negedge clk); wr_vld = 1'b1; wr_data = d;
        #1 ack_s = ack_w;
        @(posedge clk); #1 wr_vld = 1'b0;
    endtask

    task automatic op_rd();
        @(negedge clk); rd_vld = 1'b1;
        #1 rd_s[0] = rd0; rd_s[1] = rd1; rd_s[2] = rd2;
        @(posedge clk); #1 rd_vld = 1'b0;
    endtask

    task automatic preload(input int k, input logic [11:0] a, input logic [7:0] d);
        @(negedge clk); pre_we[k] = 1'b1; pre_addr = a; pre_data = d;
        @(posedge clk); #1 pre_we = '0;
    endtask

    task automatic t_reset();
        op_begin(7'h50); op_rd(); chk("R10 blank small", rd_s[0], 8'hFF);
        op_begin(7'h57); op_rd(); chk("R10 blank wide", rd_s[1], 8'hFF);
        op_begin(7'h20); op_rd(); chk("R10 blank ro", rd_s[2], 8'hFF);
        op_end();
    endtask

    task automatic t_claim();
        op_begin(7'h53); chk("R2 top of block", 8'(hit_s[0]), 8'd1);
        op_begin(7'h54); chk("R2 above block", 8'(hit_s[0]), 8'd0);
        op_begin(7'h4F); chk("R2 below block", 8'(hit_s[0]), 8'd0);
        op_begin(7'h57); chk("R2 single claim", 8'(hit_s), 8'b010);
        op_begin(7'h56); chk("R2 wide neighbour", 8'(hit_s[1]), 8'd0);
        op_begin(7'h20); chk("R2 ro claim", 8'(hit_s), 8'b100);
        op_end();
    endtask

    task automatic t_write_read();
        op_begin(7'h51); op_wr(8'h10);
        chk("R9 addr byte ack", 8'(ack_s), 8'b001);
        op_wr(8'hA1); chk("R5 data ack", 8'(ack_s[0]), 8'd1);
        op_wr(8'hA2); op_end();
        op_begin(7'h51); op_wr(8'h10);
        op_rd(); chk("R5 first stored", rd_s[0], 8'hA1);
        op_rd(); chk("R6 pointer stepped", rd_s[0], 8'hA2);
        op_begin(7'h50); op_wr(8'h10); op_rd();
        chk("R4 device bits in address", rd_s[0], 8'hFF);
        op_end();
    endtask

    task automatic t_begin_origin();
        preload(0, 12'h200, 8'h5C);
        op_begin(7'h52); op_rd(); chk("R3 origin at device block", rd_s[0], 8'h5C);
        op_end();
    endtask

    task automatic t_wide();
        op_begin(7'h57); op_wr(8'h3A); op_wr(8'h45);
        chk("R1 second address byte acked", 8'(ack_s[1]), 8'd1);
        op_wr(8'h77); op_end();
        op_begin(7'h57); op_wr(8'h0A); op_wr(8'h45); op_rd();
        chk("R1 two-byte word address", rd_s[1], 8'h77);
        op_begin(7'h57); op_wr(8'h00); op_wr(8'h45); op_rd();
        chk("R4 upper byte shifted", rd_s[1], 8'hFF);
        op_end();
    endtask

    task automatic t_wrap();
        preload(0, 12'h3FF, 8'h11);
        preload(0, 12'h000, 8'h22);
        op_begin(7'h53); op_wr(8'hFF);
        op_rd(); chk("R7 last byte", rd_s[0], 8'h11);
        op_rd(); chk("R7 read wraps", rd_s[0], 8'h22);
        op_begin(7'h57); op_wr(8'h0F); op_wr(8'hFF); op_wr(8'h31); op_wr(8'h32); op_end();
        op_begin(7'h57); op_wr(8'h00); op_wr(8'h00); op_rd();
        chk("R7 write wraps", rd_s[1], 8'h32);
        op_end();
    endtask

    task automatic t_readonly();
        preload(2, 12'h040, 8'h99);
        preload(2, 12'h042, 8'h77);
        op_begin(7'h20); op_wr(8'h40); op_wr(8'h55);
        chk("R8 dropped byte acked", 8'(ack_s), 8'b100);
        op_wr(8'h66); op_end();
        op_begin(7'h20); op_wr(8'h40);
        op_rd(); chk("R8 contents kept", rd_s[2], 8'h99);
        op_rd(); chk("R8 blank kept", rd_s[2], 8'hFF);
        op_begin(7'h20); op_wr(8'h40); op_wr(8'h01); op_wr(8'h02);
        op_rd(); chk("R8 pointer stepped", rd_s[2], 8'h77);
        op_end();
    endtask

    task automatic t_idle();
        op_begin(7'h50); op_wr(8'h30); op_end();
        op_wr(8'hEE); chk("R9 no ack after end", 8'(ack_s), 8'b000);
        op_begin(7'h50); op_wr(8'h30); op_rd();
        chk("R9 ignored write kept out", rd_s[0], 8'hFF);
        op_begin(7'h60); chk("R9 foreign begin", 8'(hit_s), 8'b000);
        op_wr(8'h5A); chk("R9 foreign write", 8'(ack_s), 8'b000);
        op_begin(7'h50); op_wr(8'h30); op_rd();
        chk("R9 foreign write kept out", rd_s[0], 8'hFF);
        op_end();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_claim();
        t_write_read();
        t_begin_origin();
        t_wide();
        t_wrap();
        t_readonly();
        t_idle();
        done = 1'b1;
        summary();
    end
endmodule